// File: doc/BRIEF.md
# Clipped Cursor Overlay

This block places a small bitmap cursor, held in on-chip RAM, over the pixel stream on its way out to the display. Software supplies a cursor position, a cursor size and the size of the active display area. The position is signed, so the cursor can hang off the left or top edge. A staging pulse clips the cursor against all four edges of the screen. From that clipping the block works out the visible window, the first screen coordinate and the word in the bitmap where display starts. It holds these values as a pending set.

The pending set moves into the active registers as one unit at the next frame-done pulse. The window therefore never changes in the middle of a frame. In interlaced mode each field shows every other bitmap row. A write port fills the bitmap RAM with ARGB words, and the red and blue bytes swap places as each word is written.

For every pixel that falls inside the active window, the cursor colour is mixed over the background using its 8-bit alpha.

Top module: `cursor_overlay`

## Requirements
- R1: A cursor size is legal when width ≤ MAX_DIM (16), height ≤ MAX_DIM and the two are not both greater than MAX_DIM/2 (8). An illegal size is staged as a zero width and zero height, so after the commit the cursor stays off.
- R2: A negative X gives screen X 0 and bitmap column offset −X. The visible width is the width minus that offset, saturating at 0. The Y axis works the same way, using the height.
- R3: When X plus width exceeds the active width, the visible width becomes the active width minus X, floored at 0, and screen X stays X. The Y axis works the same way against the active height.
- R4: With the interlace input high, screen Y and visible height are halved (rounding down) after clipping. The bitmap row stride also becomes twice the width.
- R5: When the committed visible width or height is zero, cursorEn is 0. cursorEn is 1 only if the enable input was high at staging and both visible dimensions are non-zero.
- R6: The write port takes ARGB words with A in [31:24], R in [23:16], G in [15:8] and B in [7:0]. It stores them as A, B, G, R from the top byte down. The red channel of the output always carries the red that was written.
- R7: A cfgWr pulse stages the clipped set. activePos ({Y[31:16], X[15:0]}), activeSize ({height[31:16], width[15:0]}) and cursorEn change only at a frameDone that follows a staging. If cfgWr and frameDone arrive in the same cycle, the commit waits for the next frameDone.
- R8: If a staged visible size differs from the active one, cursorEn drops in the cycle after cfgWr and stays low until the commit. A staging with the same visible size keeps the cursor shown.
- R9: On a cursor pixel, each output channel equals round((a·c + (255−a)·b)/255), where a is alpha, c is the cursor channel and b is the background. Alpha 0 passes the background and alpha 255 gives the cursor colour.
- R10: outValid and outPix appear two clocks after pixValid. A pixel outside the window, or any pixel while cursorEn is 0, passes bgPix through unchanged. Pixels use the {R[23:16], G[15:8], B[7:0]} layout.
- R11: After reset, activePos, activeSize, cursorEn and outValid are all 0.
- R12: A window pixel at row r and column c reads bitmap word (rowOffset + r)·stride + colOffset + c. Here stride is the cursor width, or twice the width in interlaced mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| curX | input | 16 | Signed cursor X |
| curY | input | 16 | Signed cursor Y |
| curW | input | 8 | Cursor width |
| curH | input | 8 | Cursor height |
| curOn | input | 1 | Cursor wanted on |
| interlaced | input | 1 | Interlaced field timing |
| actW | input | 16 | Active display width |
| actH | input | 16 | Active display height |
| cfgWr | input | 1 | Stage clipped geometry |
| frameDone | input | 1 | Frame-done event, commits staged set |
| wrEn | input | 1 | Bitmap RAM write enable |
| wrAddr | input | 7 | Bitmap RAM word address |
| wrData | input | 32 | ARGB pixel to store |
| pixValid | input | 1 | Background pixel valid |
| pixX | input | 16 | Background pixel column |
| pixY | input | 16 | Background pixel row |
| bgPix | input | 24 | Background RGB |
| outValid | output | 1 | Output pixel valid |
| outPix | output | 24 | Blended RGB |
| activePos | output | 32 | Committed screen position |
| activeSize | output | 32 | Committed visible size |
| cursorEn | output | 1 | Cursor shown |

## Verification
A table of cursor placements exercises the clipping logic. The cases are fully inside the screen, hanging off each of the four edges, lying entirely off-screen, interlaced with odd and single-line heights, illegal sizes and a disabled cursor. Each placement shows whether the offset, screen start and saturating width come from the right branch.

Directed steps then stage a new placement without a frame-done, raise staging and frame-done together, and change the size against a move of the same size. Together these separate atomic commit from early hiding.

Pixels are also sent inside and outside each window edge and through a shifted or interlaced window. They show that the bitmap addressing and stride are correct. Fractional, zero and full alpha tell blending apart from selection.

// File: rtl/cursor_pkg.sv
package cursor_pkg;
  localparam int COORD_W = 16;
  localparam int GEOM_W  = 8;

  typedef struct packed {
    logic stage;
    logic hide;
    logic commit;
  } ctlStrobe_t;

  typedef struct packed {
    logic [COORD_W-1:0] scr;
    logic [COORD_W-1:0] off;
    logic [GEOM_W-1:0]  vis;
  } axisClip_t;

  typedef struct packed {
    logic [COORD_W-1:0] scrX;
    logic [COORD_W-1:0] scrY;
    logic [GEOM_W-1:0]  visW;
    logic [GEOM_W-1:0]  visH;
    logic [COORD_W-1:0] base;
    logic [GEOM_W:0]    stride;
    logic               show;
  } curGeom_t;

  // Clip one axis against [0, lim): start, bitmap offset, visible length.
  function automatic axisClip_t clipAxis(input logic [COORD_W-1:0] pos,
                                         input logic [GEOM_W-1:0]  len,
                                         input logic [COORD_W-1:0] lim);
    axisClip_t r;
    logic signed [COORD_W+1:0] ps, ls, lm, d;
    ps = {{2{pos[COORD_W-1]}}, pos};
    ls = {{(COORD_W+2-GEOM_W){1'b0}}, len};
    lm = {2'b00, lim};
    r  = '0;
    if (ps < 0) begin
      d     = ls + ps;
      r.off = COORD_W'(-ps);
      r.scr = '0;
      r.vis = (d > 0) ? GEOM_W'(d) : '0;
    end else if (ps + ls > lm) begin
      d     = lm - ps;
      r.scr = pos;
      r.vis = (d > 0) ? GEOM_W'(d) : '0;
    end else begin
      d     = '0;
      r.scr = pos;
      r.vis = len;
    end
    return r;
  endfunction
endpackage

// File: rtl/cursor_ctrl.sv
module cursor_ctrl
  import cursor_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgWr,
  input  logic       frameDone,
  input  logic       sizeDiffers,
  output ctlStrobe_t strobe
);
  logic pendingQ;

  always_comb begin
    strobe.stage  = cfgWr;
    strobe.hide   = cfgWr && sizeDiffers;
    // a staging in the same cycle defers the commit
    strobe.commit = frameDone && pendingQ && !cfgWr;
  end

  always_ff @(posedge clk) begin
    if (!rstN)              pendingQ <= 1'b0;
    else if (cfgWr)         pendingQ <= 1'b1;
    else if (strobe.commit) pendingQ <= 1'b0;
  end

  assert_commit_clears_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commit |=> !pendingQ);
  assert_stage_sets_R7: assert property (@(posedge clk) disable iff (!rstN)
    cfgWr |=> pendingQ);
endmodule

// File: rtl/cursor_datapath.sv
module cursor_datapath
  import cursor_pkg::*;
#(
  parameter int MAX_DIM = 16,
  parameter int DEPTH   = MAX_DIM * MAX_DIM / 2,
  parameter int ADDR_W  = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobe_t         strobe,
  input  logic [COORD_W-1:0] curX,
  input  logic [COORD_W-1:0] curY,
  input  logic [GEOM_W-1:0]  curW,
  input  logic [GEOM_W-1:0]  curH,
  input  logic               curOn,
  input  logic               interlaced,
  input  logic [COORD_W-1:0] actW,
  input  logic [COORD_W-1:0] actH,
  output logic               sizeDiffers,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [31:0]        wrData,
  input  logic               pixValid,
  input  logic [COORD_W-1:0] pixX,
  input  logic [COORD_W-1:0] pixY,
  input  logic [23:0]        bgPix,
  output logic               s1Valid,
  output logic               s1Hit,
  output logic [31:0]        s1Word,
  output logic [23:0]        s1Bg,
  output logic [31:0]        activePos,
  output logic [31:0]        activeSize,
  output logic               cursorEn
);
  localparam logic [GEOM_W-1:0] MAX_L  = GEOM_W'(MAX_DIM);
  localparam logic [GEOM_W-1:0] HALF_L = GEOM_W'(MAX_DIM / 2);

  logic              legal;
  logic [GEOM_W-1:0] effW, effH;
  axisClip_t         cx, cy;
  curGeom_t          newGeom, pend, act;
  logic              curEnQ;

  // clipping of the requested placement
  always_comb begin
    legal = (curW <= MAX_L) && (curH <= MAX_L) && !((curW > HALF_L) && (curH > HALF_L));
    effW  = legal ? curW : '0;
    effH  = legal ? curH : '0;
    cx    = clipAxis(curX, effW, actW);
    cy    = clipAxis(curY, effH, actH);
    newGeom.scrX   = cx.scr;
    newGeom.visW   = cx.vis;
    newGeom.stride = interlaced ? {effW, 1'b0} : {1'b0, effW};
    newGeom.scrY   = interlaced ? (cy.scr >> 1) : cy.scr;
    newGeom.visH   = interlaced ? (cy.vis >> 1) : cy.vis;
    newGeom.base   = COORD_W'(cy.off * newGeom.stride + cx.off);
    newGeom.show   = curOn && (newGeom.visW != '0) && (newGeom.visH != '0);
    sizeDiffers    = {newGeom.visH, newGeom.visW} != {act.visH, act.visW};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pend    <= '0;
      act     <= '0;
      curEnQ  <= 1'b0;
    end else begin
      if (strobe.stage) pend <= newGeom;
      if (strobe.commit) begin
        act    <= pend;
        curEnQ <= pend.show;
      end else if (strobe.hide) begin
        curEnQ <= 1'b0;
      end
    end
  end

  assign activePos  = {act.scrY, act.scrX};
  assign activeSize = {{(16-GEOM_W){1'b0}}, act.visH, {(16-GEOM_W){1'b0}}, act.visW};
  assign cursorEn   = curEnQ;

  // bitmap RAM, stored as A,B,G,R
  logic [31:0]       mem [DEPTH];
  logic [COORD_W-1:0] relX, relY;
  logic               hitNow;
  logic [ADDR_W-1:0]  rdAddr;

  always_ff @(posedge clk) begin
    if (wrEn) mem[wrAddr] <= {wrData[31:24], wrData[7:0], wrData[15:8], wrData[23:16]};
  end

  always_comb begin
    relX   = pixX - act.scrX;
    relY   = pixY - act.scrY;
    hitNow = curEnQ
          && (pixX >= act.scrX) && (relX < {{(COORD_W-GEOM_W){1'b0}}, act.visW})
          && (pixY >= act.scrY) && (relY < {{(COORD_W-GEOM_W){1'b0}}, act.visH});
    rdAddr = ADDR_W'(act.base + relY * act.stride + relX);
  end

  always_ff @(posedge clk) begin
    s1Word <= mem[rdAddr];
    if (!rstN) begin
      s1Valid <= 1'b0;
      s1Hit   <= 1'b0;
      s1Bg    <= '0;
    end else begin
      s1Valid <= pixValid;
      s1Hit   <= pixValid && hitNow;
      s1Bg    <= bgPix;
    end
  end

  assert_en_visible_R5: assert property (@(posedge clk) disable iff (!rstN)
    curEnQ |-> (act.visW != '0) && (act.visH != '0));
  assert_hold_until_commit_R7: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.commit |=> $stable(act));
  assert_hide_on_resize_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.hide |=> !curEnQ);
  assert_size_bound_R1: assert property (@(posedge clk) disable iff (!rstN)
    (act.visW <= MAX_L) && (act.visH <= MAX_L));
endmodule

// File: rtl/cursor_blend.sv
module cursor_blend (
  input  logic        clk,
  input  logic        rstN,
  input  logic        s1Valid,
  input  logic        s1Hit,
  input  logic [31:0] s1Word,
  input  logic [23:0] s1Bg,
  output logic        outValid,
  output logic [23:0] outPix
);
  logic [7:0]  alpha;
  logic [23:0] blendPix;

  assign alpha = s1Word[31:24];

  // stored word: [7:0]=R, [15:8]=G, [23:16]=B; pixel: [23:16]=R
  for (genvar ch = 0; ch < 3; ch++) begin : g_ch
    logic [7:0]  curC, bgC;
    logic [15:0] mix;
    logic [16:0] t;
    assign curC = s1Word[8*ch +: 8];
    assign bgC  = s1Bg[8*(2-ch) +: 8];
    assign mix  = 16'(alpha) * 16'(curC) + 16'(8'd255 - alpha) * 16'(bgC);
    assign t    = 17'(mix) + 17'd128;
    assign blendPix[8*(2-ch) +: 8] = 8'((t + (t >> 8)) >> 8);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outPix   <= '0;
    end else begin
      outValid <= s1Valid;
      outPix   <= s1Hit ? blendPix : s1Bg;
    end
  end

  assert_latency_R10: assert property (@(posedge clk) disable iff (!rstN)
    s1Valid |=> outValid);
  assert_alpha_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    (s1Valid && s1Hit && (s1Word[31:24] == 8'd0)) |=> (outPix == $past(s1Bg)));
  assert_miss_passes_R10: assert property (@(posedge clk) disable iff (!rstN)
    (s1Valid && !s1Hit) |=> (outPix == $past(s1Bg)));
endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay
  import cursor_pkg::*;
#(
  parameter int MAX_DIM = 16,
  localparam int DEPTH  = MAX_DIM * MAX_DIM / 2,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [15:0]       curX,
  input  logic [15:0]       curY,
  input  logic [7:0]        curW,
  input  logic [7:0]        curH,
  input  logic              curOn,
  input  logic              interlaced,
  input  logic [15:0]       actW,
  input  logic [15:0]       actH,
  input  logic              cfgWr,
  input  logic              frameDone,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [31:0]       wrData,
  input  logic              pixValid,
  input  logic [15:0]       pixX,
  input  logic [15:0]       pixY,
  input  logic [23:0]       bgPix,
  output logic              outValid,
  output logic [23:0]       outPix,
  output logic [31:0]       activePos,
  output logic [31:0]       activeSize,
  output logic              cursorEn
);
  ctlStrobe_t  strobe;
  logic        sizeDiffers;
  logic        s1Valid, s1Hit;
  logic [31:0] s1Word;
  logic [23:0] s1Bg;

  cursor_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .cfgWr(cfgWr), .frameDone(frameDone),
    .sizeDiffers(sizeDiffers), .strobe(strobe)
  );

  cursor_datapath #(.MAX_DIM(MAX_DIM)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .curX(curX), .curY(curY), .curW(curW), .curH(curH), .curOn(curOn),
    .interlaced(interlaced), .actW(actW), .actH(actH), .sizeDiffers(sizeDiffers),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .pixValid(pixValid), .pixX(pixX), .pixY(pixY), .bgPix(bgPix),
    .s1Valid(s1Valid), .s1Hit(s1Hit), .s1Word(s1Word), .s1Bg(s1Bg),
    .activePos(activePos), .activeSize(activeSize), .cursorEn(cursorEn)
  );

  cursor_blend blend_i (
    .clk(clk), .rstN(rstN), .s1Valid(s1Valid), .s1Hit(s1Hit),
    .s1Word(s1Word), .s1Bg(s1Bg), .outValid(outValid), .outPix(outPix)
  );
endmodule

// File: tb/cursor_overlay_tb.sv
module cursor_overlay_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] curX = '0, curY = '0;
  logic [7:0]  curW = '0, curH = '0;
  logic        curOn = 1'b0, interlaced = 1'b0;
  logic [15:0] actW = 16'd100, actH = 16'd50;
  logic        cfgWr = 1'b0, frameDone = 1'b0, wrEn = 1'b0;
  logic [6:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic        pixValid = 1'b0;
  logic [15:0] pixX = '0, pixY = '0;
  logic [23:0] bgPix = '0;
  logic        outValid, cursorEn;
  logic [23:0] outPix;
  logic [31:0] activePos, activeSize;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  cursor_overlay dut_i (
    .clk(clk), .rstN(rstN), .curX(curX), .curY(curY), .curW(curW), .curH(curH),
    .curOn(curOn), .interlaced(interlaced), .actW(actW), .actH(actH),
    .cfgWr(cfgWr), .frameDone(frameDone), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .pixValid(pixValid), .pixX(pixX), .pixY(pixY), .bgPix(bgPix),
    .outValid(outValid), .outPix(outPix), .activePos(activePos),
    .activeSize(activeSize), .cursorEn(cursorEn)
  );

  typedef struct packed {
    logic signed [15:0] x;
    logic signed [15:0] y;
    logic [7:0]  w;
    logic [7:0]  h;
    logic        il;
    logic        on;
    logic [31:0] pos;
    logic [31:0] size;
    logic        en;
  } clipVec_t;

  localparam int NVEC = 14;
  localparam clipVec_t VECS [NVEC] = '{
    '{16'sd10,  16'sd5,  8'd8,  8'd8, 1'b0, 1'b1, 32'h0005_000A, 32'h0008_0008, 1'b1}, // inside
    '{-16'sd3,  16'sd4,  8'd8,  8'd16,1'b0, 1'b1, 32'h0004_0000, 32'h0010_0005, 1'b1}, // R2 left
    '{-16'sd10, 16'sd0,  8'd8,  8'd8, 1'b0, 1'b1, 32'h0000_0000, 32'h0008_0000, 1'b0}, // R2 R5 off left
    '{16'sd95,  16'sd45, 8'd16, 8'd4, 1'b0, 1'b1, 32'h002D_005F, 32'h0004_0005, 1'b1}, // R3 right
    '{16'sd120, 16'sd0,  8'd8,  8'd8, 1'b0, 1'b1, 32'h0000_0078, 32'h0008_0000, 1'b0}, // R3 R5 off right
    '{16'sd2,  -16'sd2,  8'd4,  8'd6, 1'b0, 1'b1, 32'h0000_0002, 32'h0004_0004, 1'b1}, // R2 top
    '{16'sd0,  -16'sd6,  8'd4,  8'd6, 1'b0, 1'b1, 32'h0000_0000, 32'h0000_0004, 1'b0}, // R2 R5 off top
    '{16'sd10,  16'sd21, 8'd8,  8'd9, 1'b1, 1'b1, 32'h000A_000A, 32'h0004_0008, 1'b1}, // R4 halve
    '{16'sd0,   16'sd0,  8'd4,  8'd1, 1'b1, 1'b1, 32'h0000_0000, 32'h0000_0004, 1'b0}, // R4 R5 height 1
    '{16'sd1,   16'sd1,  8'd9,  8'd9, 1'b0, 1'b1, 32'h0001_0001, 32'h0000_0000, 1'b0}, // R1 both > half
    '{16'sd0,   16'sd0,  8'd17, 8'd2, 1'b0, 1'b1, 32'h0000_0000, 32'h0000_0000, 1'b0}, // R1 too wide
    '{16'sd0,   16'sd0,  8'd16, 8'd8, 1'b0, 1'b1, 32'h0000_0000, 32'h0008_0010, 1'b1}, // R1 max legal
    '{-16'sd2,  16'sd48, 8'd6,  8'd6, 1'b0, 1'b1, 32'h0030_0000, 32'h0002_0004, 1'b1}, // R2 R3 corner
    '{16'sd5,   16'sd5,  8'd4,  8'd4, 1'b0, 1'b0, 32'h0005_0005, 32'h0004_0004, 1'b0}  // R5 enable low
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic stage(input logic [15:0] x, input logic [15:0] y, input logic [7:0] w,
                       input logic [7:0] h, input logic il, input logic on);
    @(negedge clk);
    curX = x; curY = y; curW = w; curH = h; interlaced = il; curOn = on; cfgWr = 1'b1;
    @(negedge clk);
    cfgWr = 1'b0;
  endtask

  task automatic commit();
    @(negedge clk); frameDone = 1'b1;
    @(negedge clk); frameDone = 1'b0;
  endtask

  task automatic sendPix(input logic [15:0] x, input logic [15:0] y, input logic [23:0] bg,
                         output logic [23:0] got, output logic gotV);
    @(negedge clk); pixValid = 1'b1; pixX = x; pixY = y; bgPix = bg;
    @(negedge clk); pixValid = 1'b0;
    @(negedge clk); got = outPix; gotV = outValid;
  endtask

  function automatic logic [23:0] wordColour(input int a);
    logic [7:0] b;
    b = 8'(a);
    return {b, ~b, b ^ 8'h5A};
  endfunction

  function automatic logic [7:0] mixCh(input int a, input int c, input int b);
    return 8'((a * c + (255 - a) * b + 127) / 255);
  endfunction

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [23:0] got;
    logic        gotV;
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 activePos", activePos, 32'h0);
    check("R11 activeSize", activeSize, 32'h0);
    check("R11 cursorEn", {31'b0, cursorEn}, 32'h0);
    check("R11 outValid", {31'b0, outValid}, 32'h0);
    rstN = 1'b1;

    // fill bitmap: A=FF, R=a, G=~a, B=a^5A (R6 layout of input)
    for (int a = 0; a < 128; a++) begin
      @(negedge clk);
      wrEn = 1'b1; wrAddr = 7'(a);
      wrData = {8'hFF, 8'(a), ~8'(a), 8'(a) ^ 8'h5A};
    end
    @(negedge clk); wrEn = 1'b0;

    // clipping table: R1 R2 R3 R4 R5
    for (int i = 0; i < NVEC; i++) begin
      stage(VECS[i].x, VECS[i].y, VECS[i].w, VECS[i].h, VECS[i].il, VECS[i].on);
      commit();
      check($sformatf("R7 clip pos vec %0d", i), activePos, VECS[i].pos);
      check($sformatf("R7 clip size vec %0d", i), activeSize, VECS[i].size);
      check($sformatf("R5 clip enable vec %0d", i), {31'b0, cursorEn}, {31'b0, VECS[i].en});
    end

    // R7 / R8 directed
    stage(16'd10, 16'd5, 8'd8, 8'd8, 1'b0, 1'b1);
    commit();
    check("R5 base enable", {31'b0, cursorEn}, 32'h1);
    stage(16'd20, 16'd5, 8'd8, 8'd8, 1'b0, 1'b1);
    check("R8 same size keeps shown", {31'b0, cursorEn}, 32'h1);
    check("R7 pos held before frame done", activePos, 32'h0005_000A);
    commit();
    check("R7 pos after frame done", activePos, 32'h0005_0014);
    stage(16'd20, 16'd5, 8'd4, 8'd8, 1'b0, 1'b1);
    check("R8 resize hides", {31'b0, cursorEn}, 32'h0);
    @(negedge clk); cfgWr = 1'b1; frameDone = 1'b1;
    @(negedge clk); cfgWr = 1'b0; frameDone = 1'b0;
    check("R7 coincident defers size", activeSize, 32'h0008_0008);
    check("R8 still hidden", {31'b0, cursorEn}, 32'h0);
    commit();
    check("R7 deferred commit size", activeSize, 32'h0008_0004);
    check("R7 deferred commit enable", {31'b0, cursorEn}, 32'h1);
    commit();
    check("R7 idle frame done holds", activePos, 32'h0005_0014);

    // pixels: cursor at (10,5) 8x8, stride 8, base 0
    stage(16'd10, 16'd5, 8'd8, 8'd8, 1'b0, 1'b1);
    commit();
    sendPix(16'd12, 16'd7, 24'h123456, got, gotV);
    check("R10 valid latency", {31'b0, gotV}, 32'h1);
    check("R12 R6 inside pixel word 18", {8'h0, got}, {8'h0, wordColour(18)});
    sendPix(16'd9, 16'd7, 24'h123456, got, gotV);
    check("R10 left of window", {8'h0, got}, 32'h0012_3456);
    sendPix(16'd17, 16'd12, 24'h123456, got, gotV);
    check("R12 last pixel word 63", {8'h0, got}, {8'h0, wordColour(63)});
    sendPix(16'd18, 16'd12, 24'h123456, got, gotV);
    check("R10 right of window", {8'h0, got}, 32'h0012_3456);
    sendPix(16'd17, 16'd13, 24'h123456, got, gotV);
    check("R10 below window", {8'h0, got}, 32'h0012_3456);

    // negative X: column offset 3
    stage(-16'sd3, 16'd4, 8'd8, 8'd16, 1'b0, 1'b1);
    commit();
    sendPix(16'd0, 16'd4, 24'h0, got, gotV);
    check("R2 R12 offset word 3", {8'h0, got}, {8'h0, wordColour(3)});
    sendPix(16'd4, 16'd6, 24'h0, got, gotV);
    check("R12 offset word 23", {8'h0, got}, {8'h0, wordColour(23)});
    sendPix(16'd5, 16'd4, 24'h0ABCDE, got, gotV);
    check("R2 clipped column passes bg", {8'h0, got}, 32'h000A_BCDE);

    // interlaced: stride 16, screen Y 10
    stage(16'd10, 16'd21, 8'd8, 8'd9, 1'b1, 1'b1);
    commit();
    sendPix(16'd11, 16'd11, 24'h0, got, gotV);
    check("R4 doubled stride word 17", {8'h0, got}, {8'h0, wordColour(17)});

    // blending
    stage(16'd10, 16'd5, 8'd8, 8'd8, 1'b0, 1'b1);
    commit();
    @(negedge clk); wrEn = 1'b1; wrAddr = 7'd0; wrData = 32'h80C8_0064;
    @(negedge clk); wrAddr = 7'd1; wrData = 32'h00FF_FFFF;
    @(negedge clk); wrEn = 1'b0;
    sendPix(16'd10, 16'd5, 24'h282828, got, gotV);
    check("R9 half alpha", {8'h0, got},
          {8'h0, mixCh(128, 200, 40), mixCh(128, 0, 40), mixCh(128, 100, 40)});
    sendPix(16'd11, 16'd5, 24'h282828, got, gotV);
    check("R9 alpha zero passes bg", {8'h0, got}, 32'h0028_2828);
    sendPix(16'd12, 16'd5, 24'h282828, got, gotV);
    check("R9 full alpha replaces", {8'h0, got}, {8'h0, wordColour(2)});

    // cursor disabled: bg passes
    stage(16'd10, 16'd5, 8'd8, 8'd8, 1'b0, 1'b0);
    commit();
    sendPix(16'd12, 16'd7, 24'h445566, got, gotV);
    check("R10 disabled passes bg", {8'h0, got}, 32'h0044_5566);

    finishRun();
  end
endmodule